// File: doc/BRIEF.md
# USB Low/Full-Speed Receive Bit Framer

This block sits behind a line sampler that has already recovered one symbol per bit period from the differential pair. On each sample strobe it takes a two-bit line state and turns the symbol sequence into the packet bit stream of a USB low- or full-speed link. It finds the start of a packet, undoes the NRZI line coding, drops the bits the transmitter inserted after runs of ones, and recognises the single-ended-zero end-of-packet sequence. It also aborts the packet and flags an error when the stuffing rule or the end sequence is broken.

Every result is a single-cycle pulse in the clock cycle that follows the strobe that caused it. A downstream packet layer assembles bytes from the data-bit pulses and uses the start, end and error pulses to frame them. Checking of packet identifiers and CRCs is left to that layer.

Top module: `usbrx_rx`

## Requirements
- R1: While reset is high, and in the first cycle after it, all output pulses are low. The framer starts idle, with the remembered previous symbol set to J.
- R2: The symbol input is encoded 0 = SE0, 1 = J, 2 = K and 3 = SE1. When idle, a strobed K whose previously strobed symbol was J produces a start-of-packet pulse. A K that follows any other symbol, such as SE1, produces nothing.
- R3: Inside a packet, a strobed J or K that equals the previous symbol is delivered as a data bit of value 1.
- R4: A bit that follows six consecutive decoded ones and decodes as 0 is a stuff bit. It gives a stuff pulse and no data bit, and it clears the run of ones.
- R5: A bit that follows six consecutive decoded ones and decodes as 1 gives an error pulse and returns the framer to idle.
- R6: A J or K that differs from the previous symbol is delivered as a data bit of value 0 and clears the run of ones. The run is also cleared at start of packet.
- R7: A strobed SE0 inside a packet begins the end sequence and gives no data bit. Further SE0 strobes are accepted, and a following J gives an end-of-packet pulse.
- R8: A K or SE1 strobed during the end sequence gives an error pulse and returns the framer to idle.
- R9: After a good end of packet, or after an SE0 seen while idle, the framer ignores symbols until the first non-SE0 strobe. That strobe produces nothing and re-enters idle with the previous symbol forced to J.
- R10: An SE1 strobed inside a packet gives an error pulse, no data bit, and returns the framer to idle.
- R11: Outputs pulse only in the cycle after a strobe, and for one cycle. At most one of start, data bit, stuff, end and error is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample strobe, one per bit period |
| smp_sym_i | input | 2 | Sampled line state: 0 SE0, 1 J, 2 K, 3 SE1 |
| sop_o | output | 1 | Start-of-packet pulse |
| bit_vld_o | output | 1 | Data bit pulse |
| bit_val_o | output | 1 | Value of the data bit, valid with bit_vld_o |
| stuff_o | output | 1 | Stuff bit removed |
| eop_o | output | 1 | End-of-packet pulse |
| err_o | output | 1 | Stuffing or end-sequence error, packet aborted |

## Verification
A wrong remembered symbol shows up as an inverted data bit on the very next strobe. After an error or end of packet, it also shows up as a lost or spurious start pulse. A wrong ones counter stays hidden until a run reaches six, and then appears as a missing stuff pulse, a spurious error, or a stuff bit delivered as data. A wrong framing state shows within one strobe as a data bit where an end or error was due, or as a start pulse while the bus is still in SE0. The bench compares every output on every clock against a behavioural model, so each of these faults is reported at the first strobe where it has an effect.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'd0,
        SYM_J   = 2'd1,
        SYM_K   = 2'd2,
        SYM_SE1 = 2'd3
    } sym_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BIT,
        ST_EOP,
        ST_WAIT
    } fsm_e;

    typedef struct packed {
        logic sop;
        logic bit_vld;
        logic bit_val;
        logic stuff;
        logic eop;
        logic err;
    } evt_t;

    localparam int unsigned STUFF_RUN = 6;

    function automatic logic is_data_sym(input sym_e s);
        return (s == SYM_J) || (s == SYM_K);
    endfunction

endpackage

// File: rtl/usbrx_nrzi.sv
module usbrx_nrzi
    import usbrx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic force_j,
    input  sym_e sym,
    output logic same,
    output sym_e prev
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= SYM_J;
        end else if (force_j) begin
            prev <= SYM_J;
        end else if (adv) begin
            prev <= sym;
        end
    end

    assign same = (sym == prev);

endmodule

// File: rtl/usbrx_destuff.sv
module usbrx_destuff #(
    parameter int unsigned RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic clr,
    input  logic bit_in,
    output logic stuff,
    output logic viol
);

    localparam int unsigned CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] ones;
    logic          full;

    assign full  = (ones == CW'(RUN_LEN));
    assign stuff = full & ~bit_in;
    assign viol  = full & bit_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones <= '0;
        end else if (clr) begin
            ones <= '0;
        end else if (adv) begin
            if (full || !bit_in) begin
                ones <= '0;
            end else begin
                ones <= ones + 1'b1;
            end
        end
    end

endmodule

// File: rtl/usbrx_rx.sv
module usbrx_rx
    import usbrx_pkg::*;
#(
    parameter int unsigned RUN_LEN = STUFF_RUN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_vld_i,
    input  logic [1:0] smp_sym_i,
    output logic       sop_o,
    output logic       bit_vld_o,
    output logic       bit_val_o,
    output logic       stuff_o,
    output logic       eop_o,
    output logic       err_o
);

    sym_e sym;
    sym_e prev;
    fsm_e st_q, st_n;
    evt_t evt_q, evt_n;
    logic same, ds_adv, ds_clr, ds_stuff, ds_viol, force_j;

    assign sym = sym_e'(smp_sym_i);

    usbrx_nrzi u_nrzi (
        .clk     (clk),
        .rst     (rst),
        .adv     (smp_vld_i),
        .force_j (force_j),
        .sym     (sym),
        .same    (same),
        .prev    (prev)
    );

    usbrx_destuff #(.RUN_LEN(RUN_LEN)) u_destuff (
        .clk    (clk),
        .rst    (rst),
        .adv    (ds_adv),
        .clr    (ds_clr),
        .bit_in (same),
        .stuff  (ds_stuff),
        .viol   (ds_viol)
    );

    always_comb begin
        st_n   = st_q;
        evt_n  = '0;
        ds_adv = 1'b0;
        ds_clr = 1'b0;
        if (smp_vld_i) begin
            case (st_q)
                ST_IDLE: begin
                    if (sym == SYM_SE0) begin
                        st_n = ST_WAIT;
                    end else if (sym == SYM_K && prev == SYM_J) begin
                        evt_n.sop = 1'b1;
                        ds_clr    = 1'b1;
                        st_n      = ST_BIT;
                    end
                end
                ST_BIT: begin
                    if (sym == SYM_SE0) begin
                        st_n = ST_EOP;
                    end else if (!is_data_sym(sym)) begin
                        evt_n.err = 1'b1;
                        st_n      = ST_IDLE;
                    end else begin
                        ds_adv = 1'b1;
                        if (ds_viol) begin
                            evt_n.err = 1'b1;
                            st_n      = ST_IDLE;
                        end else if (ds_stuff) begin
                            evt_n.stuff = 1'b1;
                        end else begin
                            evt_n.bit_vld = 1'b1;
                            evt_n.bit_val = same;
                        end
                    end
                end
                ST_EOP: begin
                    if (sym == SYM_J) begin
                        evt_n.eop = 1'b1;
                        st_n      = ST_WAIT;
                    end else if (sym != SYM_SE0) begin
                        evt_n.err = 1'b1;
                        st_n      = ST_IDLE;
                    end
                end
                default: begin
                    if (sym != SYM_SE0) begin
                        st_n = ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign force_j = (st_n == ST_IDLE) && (st_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            evt_q <= '0;
        end else begin
            st_q  <= st_n;
            evt_q <= evt_n;
        end
    end

    assign sop_o     = evt_q.sop;
    assign bit_vld_o = evt_q.bit_vld;
    assign bit_val_o = evt_q.bit_val;
    assign stuff_o   = evt_q.stuff;
    assign eop_o     = evt_q.eop;
    assign err_o     = evt_q.err;

endmodule

// File: rtl/usbrx_chk.sv
module usbrx_chk (
    input logic       clk,
    input logic       rst,
    input logic       smp_vld_i,
    input logic [1:0] smp_sym_i,
    input logic       sop_o,
    input logic       bit_vld_o,
    input logic       stuff_o,
    input logic       eop_o,
    input logic       err_o
);

    logic any_evt;
    assign any_evt = sop_o | bit_vld_o | stuff_o | eop_o | err_o;

    assert_onehot_evt_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sop_o, bit_vld_o, stuff_o, eop_o, err_o}));

    assert_evt_needs_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        any_evt |-> $past(smp_vld_i));

    assert_sop_on_k_R2: assert property (@(posedge clk) disable iff (rst)
        sop_o |-> ($past(smp_sym_i) == 2'd2));

    assert_eop_on_j_R7: assert property (@(posedge clk) disable iff (rst)
        eop_o |-> ($past(smp_sym_i) == 2'd1));

    assert_bit_from_jk_R3: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |-> ($past(smp_sym_i) == 2'd1 || $past(smp_sym_i) == 2'd2));

    assert_stuff_from_jk_R4: assert property (@(posedge clk) disable iff (rst)
        stuff_o |-> ($past(smp_sym_i) == 2'd1 || $past(smp_sym_i) == 2'd2));

endmodule

bind usbrx_rx usbrx_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .smp_vld_i (smp_vld_i),
    .smp_sym_i (smp_sym_i),
    .sop_o     (sop_o),
    .bit_vld_o (bit_vld_o),
    .stuff_o   (stuff_o),
    .eop_o     (eop_o),
    .err_o     (err_o)
);

// File: tb/usbrx_rx_tb.sv
module usbrx_rx_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_vld_i = 1'b0;
    logic [1:0] smp_sym_i = 2'd1;
    logic       sop_o, bit_vld_o, bit_val_o, stuff_o, eop_o, err_o;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    int          m_st   = 0;
    int          m_prev = 1;
    int          m_ones = 0;
    logic [5:0]  exp_v  = '0;
    string       exp_tag = "R1";
    int          line   = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbrx_rx dut_i (
        .clk       (clk),
        .rst       (rst),
        .smp_vld_i (smp_vld_i),
        .smp_sym_i (smp_sym_i),
        .sop_o     (sop_o),
        .bit_vld_o (bit_vld_o),
        .bit_val_o (bit_val_o),
        .stuff_o   (stuff_o),
        .eop_o     (eop_o),
        .err_o     (err_o)
    );

    function automatic logic [5:0] act_v();
        return {sop_o, bit_vld_o, bit_val_o, stuff_o, eop_o, err_o};
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (act_v() !== exp_v) begin
            fails++;
            $display("FAIL %s: outputs {sop,bit,val,stuff,eop,err} actual %b expected %b",
                     tag, act_v(), exp_v);
        end
    endtask

    // Behavioural reference: 0 idle, 1 in packet, 2 end sequence, 3 wait for non-SE0
    task automatic model(input logic v, input int s);
        exp_v   = '0;
        exp_tag = v ? "R9" : "R11";
        if (!v) return;
        case (m_st)
            0: begin
                exp_tag = "R2";
                if (s == 0) m_st = 3;
                else if (s == 2 && m_prev == 1) begin
                    exp_v[5] = 1'b1; m_ones = 0; m_st = 1;
                end
                m_prev = s;
            end
            1: begin
                if (s == 0) begin
                    exp_tag = "R7"; m_st = 2; m_prev = s;
                end else if (s == 3) begin
                    exp_tag = "R10"; exp_v[0] = 1'b1; m_st = 0; m_prev = 1;
                end else begin
                    bit b;
                    b = (s == m_prev);
                    if (m_ones == 6) begin
                        if (b) begin
                            exp_tag = "R5"; exp_v[0] = 1'b1; m_st = 0; m_prev = 1;
                        end else begin
                            exp_tag = "R4"; exp_v[2] = 1'b1; m_ones = 0; m_prev = s;
                        end
                    end else begin
                        exp_v[4] = 1'b1; exp_v[3] = b;
                        exp_tag = b ? "R3" : "R6";
                        m_ones = b ? m_ones + 1 : 0;
                        m_prev = s;
                    end
                end
            end
            2: begin
                exp_tag = (s == 0 || s == 1) ? "R7" : "R8";
                if (s == 1) begin
                    exp_v[1] = 1'b1; m_st = 3; m_prev = s;
                end else if (s != 0) begin
                    exp_v[0] = 1'b1; m_st = 0; m_prev = 1;
                end
            end
            default: begin
                exp_tag = "R9";
                if (s != 0) begin m_st = 0; m_prev = 1; end
                else m_prev = s;
            end
        endcase
    endtask

    task automatic step(input logic v, input int s);
        @(negedge clk);
        compare(exp_tag);
        model(v, s);
        smp_vld_i = v;
        smp_sym_i = 2'(s);
    endtask

    task automatic start_pkt();
        step(1, 1);
        step(1, 2);
        line = 2;
    endtask

    task automatic send_bits(input string str);
        for (int i = 0; i < str.len(); i++) begin
            if (str[i] == "0") line = (line == 1) ? 2 : 1;
            step(1, line);
            if (i % 3 == 2) step(0, line);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_v = '0;
        compare("R1");
        rst = 1'b0;
        exp_tag = "R1";

        // R2: SE1 then K is no start; J then K is
        step(1, 1); step(1, 3); step(1, 2); step(0, 2);
        start_pkt();
        // R3 R6 R4: mixed bits, six ones then stuffed zero, end sequence R7
        send_bits("0101101111110");
        send_bits("10");
        step(1, 0); step(1, 0); step(0, 0); step(1, 1);
        step(1, 1);
        // R5: seven ones abort, then restart
        start_pkt();
        send_bits("01111111");
        start_pkt();
        send_bits("001");
        // R8: K in end sequence
        step(1, 0); step(1, 2);
        // R10: SE1 inside packet
        start_pkt();
        send_bits("110");
        step(1, 3);
        // R9: SE0 in idle, K leaving wait gives nothing, next K starts
        step(1, 0); step(1, 0); step(1, 2); step(1, 2);
        step(1, 0); step(1, 1); step(1, 1);
        // R6: start clears the run of ones
        start_pkt();
        send_bits("11111");
        step(1, 0); step(1, 1); step(1, 1);
        start_pkt();
        send_bits("1111110");
        step(1, 0); step(1, 1); step(1, 1);
        // Mixed random stream, checked against the model on every clock
        for (int n = 0; n < 3000; n++) begin
            int r;
            int s;
            r = $urandom_range(0, 19);
            s = (r == 0) ? 0 : (r == 1) ? 3 : (r < 11) ? 1 : 2;
            step(($urandom_range(0, 4) != 0), s);
        end
        step(0, 1);
        step(0, 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule